// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block gathers the event and level conditions produced by the transmit and receive FIFO logic of an SPI controller and turns them into one level-sensitive interrupt line. It holds three host-visible registers: a master interrupt gate, a status register, and a per-source enable mask. The status register records which conditions have occurred. The host may flip any of its implemented bits by writing a 1 to that position. Several bits are also cleared by hardware when the FIFO condition behind them goes away.

The FIFO logic drives single-cycle strobes: a byte queued for transmit, the transmit FIFO drained, a transmit FIFO flush, transmit underrun, transmit half-empty, a byte received, the receive FIFO read until empty, receive FIFO full, and a receive FIFO flush. The host reaches the registers through a simple word-wide read/write port with byte offsets. Reads have no side effects. A synchronous soft-reset strobe returns the block to its reset contents.

Top module: `spi_irq_agg`

## Requirements
- R1: After the asynchronous reset the gate register reads 0, the enable register reads 0, the status register reads 0x0000_0004 (only the transmit-empty bit set), and `irq` is low.
- R2: A host write to the status register (offset 0x20) inverts each implemented status bit written as 1 and leaves bits written as 0 unchanged. The implemented positions are bits 2, 3, 4, 5, 6 and 8. All other status bits always read 0.
- R3: `irq` is a register. One clock edge after the gate bit is set and any bit of (status AND enable) is 1, `irq` reads 1. One edge after either condition fails, `irq` reads 0.
- R4: The transmit-empty bit (bit 2) is set by a transmit-drained or transmit-flush strobe. It is cleared by a byte-queued strobe.
- R5: The receive-not-empty bit (bit 8) is set by a byte-received strobe. It is cleared by a receive-drained strobe or a receive-flush strobe.
- R6: A receive-full strobe sets both the receive-full bit (bit 4) and the overrun bit (bit 5). A receive-flush strobe clears bits 5 and 8 and leaves bit 4 as it is.
- R7: The underrun bit (bit 3) and the half-empty bit (bit 6) are set by their strobes. No hardware strobe clears them; only a host toggle does.
- R8: When a hardware set and a host toggle or a hardware clear reach the same status bit in the same cycle, the bit ends up 1.
- R9: The enable register (offset 0x28) keeps only the implemented status positions, and the gate register (offset 0x1C) keeps only bit 31. Reads of any other offset return 0, and writes to any other offset change nothing.
- R10: A `soft_rst` strobe returns all three registers to their R1 values and drives `irq` low on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft-reset strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 7 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when no read is active |
| tx_queued | input | 1 | A byte entered the transmit FIFO |
| tx_drained | input | 1 | The transmit FIFO became empty |
| tx_flush | input | 1 | The transmit FIFO was reset |
| tx_underrun | input | 1 | A transmit underrun occurred |
| tx_half_empty | input | 1 | The transmit FIFO fell to half-empty |
| rx_received | input | 1 | A byte entered the receive FIFO |
| rx_drained | input | 1 | The receive FIFO was read until empty |
| rx_full | input | 1 | The receive FIFO reached full |
| rx_flush | input | 1 | The receive FIFO was reset |
| irq | output | 1 | Registered level interrupt |

## Verification
Two kinds of collision can land on one status bit in the same cycle. The first is a hardware set together with a host toggle. The second is a hardware set together with a hardware clear. The bench provokes the first by writing 1 to the receive-not-empty position while also pulsing the byte-received strobe with that bit already 1. It provokes the second by pulsing the byte-received and receive-drained strobes together. In both cases the bit is judged by reading the status back on the next cycle, where it must still be 1.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_GATE = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK = 7'h28;

    localparam int GATE_BIT = 31;

    localparam int B_TX_EMPTY = 2;
    localparam int B_TX_UNDER = 3;
    localparam int B_RX_FULL  = 4;
    localparam int B_RX_OVR   = 5;
    localparam int B_TX_HALF  = 6;
    localparam int B_RX_AVAIL = 8;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << B_TX_EMPTY) | (REG_W'(1) << B_TX_UNDER) |
        (REG_W'(1) << B_RX_FULL)  | (REG_W'(1) << B_RX_OVR)   |
        (REG_W'(1) << B_TX_HALF)  | (REG_W'(1) << B_RX_AVAIL);

    localparam logic [REG_W-1:0] STAT_RST = REG_W'(1) << B_TX_EMPTY;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    parameter int GB = GATE_BIT
) (
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic          gate_q,
    input  logic [W-1:0]  stat_q,
    input  logic [W-1:0]  mask_q,
    output logic          wr_gate,
    output logic          wr_stat,
    output logic          wr_mask,
    output logic [W-1:0]  rdata
);

    always_comb begin
        wr_gate = reg_wr && (reg_addr == OFS_GATE);
        wr_stat = reg_wr && (reg_addr == OFS_STAT);
        wr_mask = reg_wr && (reg_addr == OFS_MASK);
    end

    always_comb begin
        rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                OFS_GATE: rdata = W'(gate_q) << GB;
                OFS_STAT: rdata = stat_q;
                OFS_MASK: rdata = mask_q;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int             W       = REG_W,
    parameter logic [W-1:0]   MASK    = IMPL_MASK,
    parameter logic [W-1:0]   RST_VAL = STAT_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    input  logic [W-1:0] host_tgl,
    output logic [W-1:0] stat_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_cell
            logic cell_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         cell_q <= RST_VAL[i];
                else if (soft_rst)  cell_q <= RST_VAL[i];
                else if (hw_set[i]) cell_q <= 1'b1;
                else if (hw_clr[i]) cell_q <= 1'b0;
                else                cell_q <= cell_q ^ host_tgl[i];
            end

            assign stat_q[i] = cell_q;

            // R8: a hardware set survives any same-cycle toggle or clear
            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_set[i] && !soft_rst) |=> stat_q[i]);

            // R4 / R5: a lone hardware clear empties the bit
            p_hw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_clr[i] && !hw_set[i] && !soft_rst) |=> !stat_q[i]);

            // R2: an undisturbed host toggle inverts the bit
            p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (host_tgl[i] && !hw_set[i] && !hw_clr[i] && !soft_rst)
                |=> (stat_q[i] != $past(stat_q[i])));
        end else begin : g_tie
            assign stat_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int           W    = REG_W,
    parameter int           GB   = GATE_BIT,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         wr_gate,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic         gate_q,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            mask_q <= '0;
        end else if (soft_rst) begin
            gate_q <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_gate) gate_q <= wdata[GB];
            if (wr_mask) mask_q <= wdata & MASK;
        end
    end

    // R9: the gate only moves on a write to its own offset
    p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gate && !soft_rst) |=> $stable(gate_q));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mask && !soft_rst) |=> $stable(mask_q));

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
    import spi_irq_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic          tx_queued,
    input  logic          tx_drained,
    input  logic          tx_flush,
    input  logic          tx_underrun,
    input  logic          tx_half_empty,
    input  logic          rx_received,
    input  logic          rx_drained,
    input  logic          rx_full,
    input  logic          rx_flush,
    output logic          irq
);

    logic         gate_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;
    logic         wr_gate, wr_stat, wr_mask;
    logic [W-1:0] hw_set, hw_clr, host_tgl;
    logic         irq_q;

    always_comb begin
        hw_set = '0;
        hw_clr = '0;
        hw_set[B_TX_EMPTY] = tx_drained | tx_flush;
        hw_set[B_TX_UNDER] = tx_underrun;
        hw_set[B_RX_FULL]  = rx_full;
        hw_set[B_RX_OVR]   = rx_full;
        hw_set[B_TX_HALF]  = tx_half_empty;
        hw_set[B_RX_AVAIL] = rx_received;
        hw_clr[B_TX_EMPTY] = tx_queued;
        hw_clr[B_RX_OVR]   = rx_flush;
        hw_clr[B_RX_AVAIL] = rx_drained | rx_flush;
        host_tgl = wr_stat ? reg_wdata : '0;
    end

    spi_irq_decode #(.W(W), .AW(AW), .GB(GATE_BIT)) u_decode (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .gate_q   (gate_q),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .wr_gate  (wr_gate),
        .wr_stat  (wr_stat),
        .wr_mask  (wr_mask),
        .rdata    (reg_rdata)
    );

    spi_irq_status #(.W(W), .MASK(IMPL_MASK), .RST_VAL(STAT_RST)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr),
        .host_tgl (host_tgl),
        .stat_q   (stat_q)
    );

    spi_irq_ctrl #(.W(W), .GB(GATE_BIT), .MASK(IMPL_MASK)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_gate  (wr_gate),
        .wr_mask  (wr_mask),
        .wdata    (reg_wdata),
        .gate_q   (gate_q),
        .mask_q   (mask_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (soft_rst) irq_q <= 1'b0;
        else               irq_q <= gate_q & (|(stat_q & mask_q));
    end

    assign irq = irq_q;

    // R3: with the gate closed the line is low one edge later
    p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> !irq);

    // R3: an enabled pending source raises the line one edge later
    p_pending_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && (|(stat_q & mask_q)) && !soft_rst) |=> irq);

    // R10: soft reset restores every register and drops the line
    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (stat_q == STAT_RST && mask_q == '0 && !gate_q && !irq));

endmodule

// File: tb/spi_irq_agg_tb.sv
module spi_irq_agg_tb;

    localparam int CLK_P = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  ev = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    rd_item_t sb[$];

    localparam logic [6:0] A_GATE = 7'h1C;
    localparam logic [6:0] A_STAT = 7'h20;
    localparam logic [6:0] A_MASK = 7'h28;

    // event vector bits
    localparam int E_TXQ = 0, E_TXD = 1, E_TXF = 2, E_TXU = 3, E_TXH = 4;
    localparam int E_RXR = 5, E_RXD = 6, E_RXFULL = 7, E_RXF = 8;

    always #(CLK_P/2) clk = ~clk;

    spi_irq_agg u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .tx_queued    (ev[E_TXQ]),
        .tx_drained   (ev[E_TXD]),
        .tx_flush     (ev[E_TXF]),
        .tx_underrun  (ev[E_TXU]),
        .tx_half_empty(ev[E_TXH]),
        .rx_received  (ev[E_RXR]),
        .rx_drained   (ev[E_RXD]),
        .rx_full      (ev[E_RXFULL]),
        .rx_flush     (ev[E_RXF]),
        .irq          (irq)
    );

    // monitor: compares read data a quarter period after the driving edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (reg_rd && sb.size() > 0) begin
            rd_item_t it;
            it = sb.pop_front();
            checks++;
            if (reg_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata=%08h expected=%08h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic step(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        input logic [8:0] e, input logic sr);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; ev = e; soft_rst = sr;
        @(negedge clk);
        reg_wr = 1'b0; ev = '0; soft_rst = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, 1'b0);
    endtask

    task automatic pulse(input logic [8:0] e);
        step(1'b0, '0, '0, e, 1'b0);
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_STAT, 32'h0000_0004, "R1 status");
        rd(A_MASK, 32'h0, "R1 enable");
        rd(A_GATE, 32'h0, "R1 gate");

        // R9 register widths
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, 32'h0000_017C, "R9 enable keeps implemented bits");
        wr(A_GATE, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R3 irq one edge late");
        rd(A_GATE, 32'h8000_0000, "R9 gate keeps bit 31");
        chk_irq(1'b1, "R3 irq raised by tx-empty");
        wr(A_GATE, 32'h0);
        @(negedge clk);
        chk_irq(1'b0, "R3 gate closed");

        // R2 toggles
        wr(A_STAT, 32'h0000_0004);
        rd(A_STAT, 32'h0, "R2 toggle clears bit 2");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0000_017C, "R2 toggle sets implemented only");
        wr(A_STAT, 32'h0000_017C);
        rd(A_STAT, 32'h0, "R2 toggle back to zero");

        // R4 transmit empty
        pulse(9'(1 << E_TXD));
        rd(A_STAT, 32'h0000_0004, "R4 drained sets bit 2");
        pulse(9'(1 << E_TXQ));
        rd(A_STAT, 32'h0, "R4 queued clears bit 2");
        pulse(9'(1 << E_TXF));
        rd(A_STAT, 32'h0000_0004, "R4 flush sets bit 2");
        wr(A_STAT, 32'h0000_0004);

        // R5 receive not-empty
        pulse(9'(1 << E_RXR));
        rd(A_STAT, 32'h0000_0100, "R5 received sets bit 8");
        pulse(9'(1 << E_RXD));
        rd(A_STAT, 32'h0, "R5 drained clears bit 8");

        // R6 full / overrun / flush
        pulse(9'(1 << E_RXR));
        pulse(9'(1 << E_RXFULL));
        rd(A_STAT, 32'h0000_0130, "R6 full sets bits 4 and 5");
        pulse(9'(1 << E_RXF));
        rd(A_STAT, 32'h0000_0010, "R6 flush clears 5 and 8 keeps 4");
        wr(A_STAT, 32'h0000_0010);

        // R7 sticky sources
        pulse(9'(1 << E_TXU));
        pulse(9'(1 << E_TXH));
        rd(A_STAT, 32'h0000_0048, "R7 underrun and half-empty set");
        pulse(9'((1 << E_TXQ) | (1 << E_RXD) | (1 << E_RXF)));
        rd(A_STAT, 32'h0000_0048, "R7 clears ignore sticky bits");
        wr(A_STAT, 32'h0000_0048);
        rd(A_STAT, 32'h0, "R7 host toggle clears sticky bits");

        // R8 collisions
        pulse(9'(1 << E_RXR));
        step(1'b1, A_STAT, 32'h0000_0100, 9'(1 << E_RXR), 1'b0);
        rd(A_STAT, 32'h0000_0100, "R8 set beats host toggle");
        pulse(9'((1 << E_RXR) | (1 << E_RXD)));
        rd(A_STAT, 32'h0000_0100, "R8 set beats hardware clear");
        wr(A_STAT, 32'h0000_0100);

        // R3 masked interrupt path
        wr(A_MASK, 32'h0000_0008);
        wr(A_GATE, 32'h8000_0000);
        @(negedge clk);
        chk_irq(1'b0, "R3 no pending source");
        pulse(9'(1 << E_TXU));
        chk_irq(1'b0, "R3 irq waits one edge");
        @(negedge clk);
        chk_irq(1'b1, "R3 underrun raises irq");

        // R9 unknown offset
        wr(7'h40, 32'hFFFF_FFFF);
        rd(7'h40, 32'h0, "R9 unknown offset reads zero");
        rd(A_STAT, 32'h0000_0008, "R9 unknown write leaves status");
        chk_irq(1'b1, "R9 irq unchanged");

        wr(A_MASK, 32'h0000_0040);
        @(negedge clk);
        chk_irq(1'b0, "R3 masked source drops irq");
        wr(A_MASK, 32'h0000_0008);
        @(negedge clk);
        chk_irq(1'b1, "R3 re-enabled source raises irq");

        // R10 soft reset
        step(1'b0, '0, '0, '0, 1'b1);
        chk_irq(1'b0, "R10 irq cleared by soft reset");
        rd(A_STAT, 32'h0000_0004, "R10 status after soft reset");
        rd(A_MASK, 32'h0, "R10 enable after soft reset");
        rd(A_GATE, 32'h0, "R10 gate after soft reset");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule